// File: doc/BRIEF.md
# Configurable GPIO interrupt router

Three GPIO banks produce 70 level interrupt requests: bank 0 has 14 lines, bank 1 has 24 and bank 2 has 32. The interrupt controller downstream has only 41 inputs for them. The router fills those inputs as follows:

- 38 exclusive slots, each carrying exactly one request.
- 3 shared outputs, one per bank. Each is the OR of every request in that bank that currently holds no exclusive slot.

The routing comes from a 32-bit select register that software can rewrite at any time.

The exclusive slots are laid out in a fixed order:

- Slots 0 to 13 have bank 0 lines 0 to 13 as their default owners.
- Slots 14 to 31 have bank 1 lines 0 to 17 as their default owners.
- Slots 32 to 37 are permanently bound to bank 1 lines 18 to 23.

Bit n of the select register (n from 0 to 31) hands slot n from its default owner to bank 2 line n. The displaced default owner then moves onto its bank's shared output. In the reset state bank 0 and bank 1 own every slot, and all of bank 2 shares one output.

The output paths are purely combinational from the register and the request inputs. A register write changes the routing on the clock edge that captures it. The register reads back directly, with no read strobe.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, cfg_rdata is 0, slot n (n < 14) follows bank 0 line n, and slot 14+m (m < 18) follows bank 1 line m.
- R2: With cfg_we high at a rising clock edge, cfg_rdata equals cfg_wdata from that edge on, and not before it.
- R3: For every slot n from 0 to 31 whose select bit is 1, irq_excl[n] equals irq_b2[n].
- R4: For every slot n from 0 to 31 whose select bit is 0, irq_excl[n] equals its default owner: irq_b0[n] for n < 14, irq_b1[n-14] otherwise.
- R5: irq_excl[37:32] always equals irq_b1[23:18], whatever the register holds.
- R6: irq_shared[0] is the OR of the bank 0 lines n whose select bit n is 1.
- R7: irq_shared[1] is the OR of the bank 1 lines m (m < 18) whose select bit 14+m is 1. Bank 1 lines 18 to 23 never reach irq_shared[1].
- R8: irq_shared[2] is the OR of the bank 2 lines n whose select bit n is 0.
- R9: While cfg_we is low, cfg_rdata keeps its value, whatever the request inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the select register |
| cfg_wdata | input | 32 | Value written to the select register |
| cfg_rdata | output | 32 | Current contents of the select register |
| irq_b0 | input | 14 | Bank 0 level requests |
| irq_b1 | input | 24 | Bank 1 level requests |
| irq_b2 | input | 32 | Bank 2 level requests |
| irq_excl | output | 38 | Exclusive interrupt slots |
| irq_shared | output | 3 | Per-bank shared interrupt, bit b for bank b |

## Verification
The hardest situation to reach is a single request moving between its exclusive slot and its bank's shared output when the select register changes. This must happen while the other requests of that bank are quiet, so that an OR of the wrong set of lines cannot hide the fault. The stimulus writes one-hot and one-cold select patterns and raises only one request in a bank at a time. Random register writes are then mixed with sparse random request patterns, in which each line is active with low probability. The pinned bank 1 lines are driven high under an all-ones select value, to show that they never leak onto the shared output.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
    // Registered state of the router: only the slot select word.
    typedef struct packed {
        logic [31:0] sel;
    } irqr_state_t;
endpackage

// File: rtl/irqr_cfg_reg.sv
module irqr_cfg_reg #(
    parameter int REG_W = 32,
    parameter int NSEL  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] sel
);
    // Bits at or above NSEL have no slot behind them and stay zero.
    localparam logic [REG_W-1:0] SEL_MASK = {REG_W{1'b1}} >> (REG_W - NSEL);

    logic [REG_W-1:0] sel_d;
    logic [REG_W-1:0] sel_q;

    always_comb begin
        sel_d = sel_q;
        if (we) begin
            sel_d = wdata & SEL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel = sel_q;
endmodule

// File: rtl/irqr_slot_mux.sv
module irqr_slot_mux #(
    parameter int N0    = 14,
    parameter int N1    = 24,
    parameter int N2    = 32,
    parameter int NSEL  = 32,
    parameter int REG_W = 32,
    localparam int NSLOT = N0 + N1
) (
    input  logic [REG_W-1:0] sel,
    input  logic [N0-1:0]    b0,
    input  logic [N1-1:0]    b1,
    input  logic [N2-1:0]    b2,
    output logic [NSLOT-1:0] excl
);
    for (genvar n = 0; n < NSLOT; n++) begin : g_slot
        logic owner;
        if (n < N0) begin : g_own0
            assign owner = b0[n];
        end else begin : g_own1
            assign owner = b1[n-N0];
        end
        if (n < NSEL) begin : g_swap
            assign excl[n] = sel[n] ? b2[n] : owner;
        end else begin : g_pinned
            assign excl[n] = owner;
        end
    end
endmodule

// File: rtl/irqr_share_merge.sv
module irqr_share_merge #(
    parameter int N0    = 14,
    parameter int N1    = 24,
    parameter int N2    = 32,
    parameter int NSEL  = 32,
    parameter int REG_W = 32
) (
    input  logic [REG_W-1:0] sel,
    input  logic [N0-1:0]    b0,
    input  logic [N1-1:0]    b1,
    input  logic [N2-1:0]    b2,
    output logic [2:0]       shared
);
    logic [N0-1:0] dem0;
    logic [N1-1:0] dem1;
    logic [N2-1:0] dem2;

    // A default owner is demoted when its slot's select bit is set.
    for (genvar i = 0; i < N0; i++) begin : g_d0
        if (i < NSEL) begin : g_s
            assign dem0[i] = sel[i];
        end else begin : g_z
            assign dem0[i] = 1'b0;
        end
    end
    for (genvar m = 0; m < N1; m++) begin : g_d1
        if (N0 + m < NSEL) begin : g_s
            assign dem1[m] = sel[N0+m];
        end else begin : g_z
            assign dem1[m] = 1'b0;
        end
    end
    // A bank 2 line is demoted unless its select bit claims the slot.
    for (genvar j = 0; j < N2; j++) begin : g_d2
        if (j < NSEL) begin : g_s
            assign dem2[j] = ~sel[j];
        end else begin : g_o
            assign dem2[j] = 1'b1;
        end
    end

    assign shared[0] = |(b0 & dem0);
    assign shared[1] = |(b1 & dem1);
    assign shared[2] = |(b2 & dem2);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
    parameter int N0    = 14,
    parameter int N1    = 24,
    parameter int N2    = 32,
    parameter int NFIX  = 6,
    parameter int REG_W = 32,
    localparam int NSLOT = N0 + N1,
    localparam int NSEL  = NSLOT - NFIX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic [N0-1:0]    irq_b0,
    input  logic [N1-1:0]    irq_b1,
    input  logic [N2-1:0]    irq_b2,
    output logic [NSLOT-1:0] irq_excl,
    output logic [2:0]       irq_shared
);
    logic [REG_W-1:0] sel;

    irqr_cfg_reg #(.REG_W(REG_W), .NSEL(NSEL)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .sel   (sel)
    );

    irqr_slot_mux #(.N0(N0), .N1(N1), .N2(N2), .NSEL(NSEL), .REG_W(REG_W)) u_mux (
        .sel  (sel),
        .b0   (irq_b0),
        .b1   (irq_b1),
        .b2   (irq_b2),
        .excl (irq_excl)
    );

    irqr_share_merge #(.N0(N0), .N1(N1), .N2(N2), .NSEL(NSEL), .REG_W(REG_W)) u_merge (
        .sel    (sel),
        .b0     (irq_b0),
        .b1     (irq_b1),
        .b2     (irq_b2),
        .shared (irq_shared)
    );

    assign cfg_rdata = sel;
endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
    parameter int N0    = 14,
    parameter int N1    = 24,
    parameter int N2    = 32,
    parameter int NFIX  = 6,
    parameter int REG_W = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic [REG_W-1:0]    cfg_wdata,
    input logic [REG_W-1:0]    cfg_rdata,
    input logic [N0-1:0]       irq_b0,
    input logic [N1-1:0]       irq_b1,
    input logic [N2-1:0]       irq_b2,
    input logic [N0+N1-1:0]    irq_excl,
    input logic [2:0]          irq_shared
);
    localparam int NSLOT = N0 + N1;
    localparam int NSEL  = NSLOT - NFIX;

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[NSEL-1:0] == $past(cfg_wdata[NSEL-1:0]));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_rdata));

    p_bank2_slot_r3: assert property (@(posedge clk) disable iff (rst)
        ((irq_excl[NSEL-1:0] ^ irq_b2[NSEL-1:0]) & cfg_rdata[NSEL-1:0]) == '0);

    p_bank0_slot_r4: assert property (@(posedge clk) disable iff (rst)
        ((irq_excl[N0-1:0] ^ irq_b0) & ~cfg_rdata[N0-1:0]) == '0);

    p_pinned_r5: assert property (@(posedge clk) disable iff (rst)
        irq_excl[NSLOT-1:NSEL] == irq_b1[N1-1:N1-NFIX]);

    p_quiet_shared0_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[N0-1:0] == '0) |-> !irq_shared[0]);

    p_pinned_never_shared_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_b1[N1-NFIX-1:0] == '0) |-> !irq_shared[1]);

    p_bank2_all_claimed_r8: assert property (@(posedge clk) disable iff (rst)
        ($countones(cfg_rdata[NSEL-1:0]) == NSEL && NSEL == N2) |-> !irq_shared[2]);
endmodule

bind gpio_irq_router irqr_chk #(.N0(N0), .N1(N1), .N2(N2), .NFIX(NFIX), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .irq_b0     (irq_b0),
    .irq_b1     (irq_b1),
    .irq_b2     (irq_b2),
    .irq_excl   (irq_excl),
    .irq_shared (irq_shared)
);

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/1ps
module gpio_irq_router_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [13:0] irq_b0 = '0;
    logic [23:0] irq_b1 = '0;
    logic [31:0] irq_b2 = '0;
    logic [37:0] irq_excl;
    logic [2:0]  irq_shared;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] exp_sel = '0;

    always #2.5 clk = ~clk;

    gpio_irq_router u_gpio_irq_router (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_b0(irq_b0), .irq_b1(irq_b1), .irq_b2(irq_b2),
        .irq_excl(irq_excl), .irq_shared(irq_shared)
    );

    function automatic logic [37:0] model_excl(input logic [31:0] s, input logic [13:0] a,
                                               input logic [23:0] b, input logic [31:0] c);
        logic [37:0] r;
        for (int n = 0; n < 38; n++) begin
            if (n < 32 && s[n]) r[n] = c[n];
            else if (n < 14)    r[n] = a[n];
            else                r[n] = b[n-14];
        end
        return r;
    endfunction

    function automatic logic [2:0] model_shared(input logic [31:0] s, input logic [13:0] a,
                                                input logic [23:0] b, input logic [31:0] c);
        logic [2:0] r = '0;
        for (int n = 0; n < 14; n++) if (s[n] && a[n]) r[0] = 1'b1;
        for (int m = 0; m < 18; m++) if (s[14+m] && b[m]) r[1] = 1'b1;
        for (int n = 0; n < 32; n++) if (!s[n] && c[n]) r[2] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model for the current inputs and exp_sel.
    task automatic check_all(input string ctx);
        logic [37:0] ex;
        logic [2:0]  sh;
        logic [37:0] m1;
        ex = model_excl(exp_sel, irq_b0, irq_b1, irq_b2);
        sh = model_shared(exp_sel, irq_b0, irq_b1, irq_b2);
        m1 = {6'b0, exp_sel};
        chk({"R2 readback ", ctx}, {32'b0, cfg_rdata}, {32'b0, exp_sel});
        chk({"R3 bank2 slots ", ctx}, {26'b0, irq_excl & m1}, {26'b0, ex & m1});
        chk({"R4 default slots ", ctx}, {26'b0, irq_excl & ~m1 & 38'h00_FFFF_FFFF},
            {26'b0, ex & ~m1 & 38'h00_FFFF_FFFF});
        chk({"R5 pinned slots ", ctx}, {58'b0, irq_excl[37:32]}, {58'b0, irq_b1[23:18]});
        chk({"R6 shared0 ", ctx}, {63'b0, irq_shared[0]}, {63'b0, sh[0]});
        chk({"R7 shared1 ", ctx}, {63'b0, irq_shared[1]}, {63'b0, sh[1]});
        chk({"R8 shared2 ", ctx}, {63'b0, irq_shared[2]}, {63'b0, sh[2]});
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        #1;
        chk("R2 not before edge", {32'b0, cfg_rdata}, {32'b0, exp_sel});
        @(negedge clk);
        cfg_we = 1'b0;
        exp_sel = v;
        #1;
    endtask

    task automatic drive(input logic [13:0] a, input logic [23:0] b, input logic [31:0] c);
        irq_b0 = a;
        irq_b1 = b;
        irq_b2 = c;
        #1;
    endtask

    function automatic logic [31:0] sparse(input int w);
        logic [31:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = ($urandom % 8) == 0;
        return r;
    endfunction

    initial begin
        logic [31:0] hold;
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 reset register", {32'b0, cfg_rdata}, 64'd0);
        drive(14'h2A5C, 24'h35_1E3B, 32'hFFFF_FFFF);
        chk("R1 reset slots", {26'b0, irq_excl}, {26'b0, irq_b1, irq_b0});
        chk("R1 bank2 on shared", {63'b0, irq_shared[2]}, 64'd1);
        check_all("reset");

        // R3/R8: all slots claimed by bank 2
        wr(32'hFFFF_FFFF);
        drive(14'h0, 24'hFC_0000, 32'h8000_0001);
        check_all("all ones pinned high");
        chk("R7 pinned lines never shared", {63'b0, irq_shared[1]}, 64'd0);
        chk("R8 no bank2 share", {63'b0, irq_shared[2]}, 64'd0);

        // One request moving between slot and shared output
        drive(14'h0, 24'h0, 32'h0000_0400);
        wr(32'h0000_0400);
        check_all("one hot bank2 line 10");
        chk("R3 slot 10 from bank2", {63'b0, irq_excl[10]}, 64'd1);
        wr(32'hFFFF_FBFF);
        check_all("one cold bank2 line 10");
        chk("R8 line 10 shared", {63'b0, irq_shared[2]}, 64'd1);

        drive(14'h0020, 24'h0, 32'h0);
        wr(32'h0000_0020);
        chk("R6 bank0 line 5 shared", {63'b0, irq_shared[0]}, 64'd1);
        check_all("bank0 line 5 demoted");
        drive(14'h0, 24'h02_0000, 32'h0);
        wr(32'h8000_0000);
        chk("R7 bank1 line 17 shared", {63'b0, irq_shared[1]}, 64'd1);
        check_all("bank1 line 17 demoted");
        wr(32'h0);
        chk("R4 bank1 line 17 back to slot 31", {63'b0, irq_excl[31]}, 64'd1);

        wr(32'hA5A5_5A5A);
        drive(14'h3FFF, 24'hFF_FFFF, 32'hFFFF_FFFF);
        check_all("all requests high");

        // R9: register holds while inputs move
        hold = exp_sel;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            drive(14'(sparse(14)), 24'(sparse(24)), sparse(32));
            chk("R9 register holds", {32'b0, cfg_rdata}, {32'b0, hold});
        end

        // Random mix
        for (int k = 0; k < 300; k++) begin
            if (($urandom % 3) == 0) wr($urandom);
            @(negedge clk);
            if (($urandom % 2) == 0) drive(14'(sparse(14)), 24'(sparse(24)), sparse(32));
            else drive(14'($urandom), 24'($urandom), $urandom);
            check_all("random");
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule